// File: doc/BRIEF.md
# Memory Access Qualifier and Downsampler

This block sits on a stream of memory access events and decides which of them reach a hotness tracker. Each event carries a device physical address, a read/write flag and a flag that marks a trusted-execution access. An event is kept only when two things hold. Its read/write and trusted flags must match the configured access-type code. Its address must fall inside an enabled 256 MiB region of the low device address window.

A kept address becomes a unit index: the address shifted right by a configurable power-of-two unit size. Kept events then pass through a downsampler. It lets one event in every 2^k through, or, in randomized mode, uses an interval that an LFSR spreads around the same average. Each event that passes produces one registered valid pulse with its unit index. There is no backpressure. The configuration is held on static inputs.

Top module: `acc_sampler`

## Requirements
- R1: While rst_ni is low and after its release, out_valid_o is low until an event passes. The downsampler starts empty, so the first qualifying event after reset passes.
- R2: Access code 1 keeps reads with the trusted flag clear, code 2 keeps writes with it clear, and code 3 keeps both. Any event with the trusted flag set is dropped under codes 1 to 3. The write flag is 1 for a write.
- R3: Access code 4 keeps reads, code 5 keeps writes and code 6 keeps every access, whatever the trusted flag.
- R4: Access codes 0 and 7 drop every event.
- R5: Region i (0..15) covers addresses with bits [31:28] equal to i and bits [39:32] zero. It is enabled when base <= i < base + size. A run that extends past region 15 is clipped and does not wrap. Addresses of 4 GiB and above are always dropped.
- R6: The unit index is the address shifted right by the unit exponent, truncated to 32 bits. Exponents below 8 act as 8.
- R7: With randomization off and downsampling exponent k, the first qualifying event passes. After that, every 2^k-th qualifying event passes. Dropped events do not advance the count.
- R8: Every passed event reloads the skip count. With randomization off the new count is 2^k - 1. With it on, the count is (2^k >> 1) + (L & (2^k - 1)), where L is a 16-bit Galois LFSR. The LFSR shifts right, XORs 0xB400 when the bit shifted out is 1, starts at 0xACE1, and advances once on each passed event, after its value has been used.
- R9: An event that passes on the clock edge at which it is sampled raises out_valid_o for exactly the next cycle, with its unit index on out_unit_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Access event present |
| evt_addr_i | input | 40 | Device physical address |
| evt_write_i | input | 1 | 1 = write, 0 = read |
| evt_trusted_i | input | 1 | Trusted-execution flag |
| cfg_acc_code_i | input | 3 | Access-type code 0..7 |
| cfg_region_base_i | input | 4 | First enabled region |
| cfg_region_size_i | input | 5 | Number of enabled regions, 0..16 |
| cfg_unit_log2_i | input | 6 | Unit size exponent |
| cfg_ds_log2_i | input | 4 | Downsampling exponent k |
| cfg_ds_rand_i | input | 1 | Randomized interval enable |
| out_valid_o | output | 1 | Passed-event pulse |
| out_unit_o | output | 32 | Unit index of the passed event |

## Verification
The bench builds the block with its defaults: a 40-bit address, sixteen 256 MiB regions, a minimum unit exponent of 8 and a 4-bit downsampling exponent. With these values, addresses above 4 GiB can be driven to test the window edge. Every region can be enabled so that the clipping of a run at the top of the window can be seen. Small exponents k of 2 and 3 keep enough randomized reloads inside a short run that the LFSR sequence is checked over many steps.

// File: rtl/acc_sampler_pkg.sv
package acc_sampler_pkg;
  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_RD_OPEN = 3'd1,
    ACC_WR_OPEN = 3'd2,
    ACC_RW_OPEN = 3'd3,
    ACC_RD_ALL  = 3'd4,
    ACC_WR_ALL  = 3'd5,
    ACC_RW_ALL  = 3'd6,
    ACC_RSVD    = 3'd7
  } acc_code_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/acc_type_filter.sv
module acc_type_filter
  import acc_sampler_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic       write_i,
  input  logic       trusted_i,
  output logic       match_o
);
  always_comb begin
    case (code_i)
      ACC_RD_OPEN: match_o = !write_i && !trusted_i;
      ACC_WR_OPEN: match_o =  write_i && !trusted_i;
      ACC_RW_OPEN: match_o = !trusted_i;
      ACC_RD_ALL:  match_o = !write_i;
      ACC_WR_ALL:  match_o =  write_i;
      ACC_RW_ALL:  match_o = 1'b1;
      default:     match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_region_map.sv
module acc_region_map #(
  parameter int unsigned RA_W       = 12,
  parameter int unsigned REGIONS    = 16,
  parameter int unsigned REG_IDX_W  = 4,
  parameter int unsigned REG_SIZE_W = 5
) (
  input  logic [RA_W-1:0]       addr_hi_i,
  input  logic [REG_IDX_W-1:0]  base_i,
  input  logic [REG_SIZE_W-1:0] size_i,
  output logic                  hit_o
);
  localparam int unsigned MAP_N = 1 << REG_IDX_W;
  localparam int unsigned SUM_W = REG_SIZE_W + 1;

  logic [MAP_N-1:0]     map;
  logic [SUM_W-1:0]     lo, hi;
  logic [REG_IDX_W-1:0] idx;
  logic                 in_window;

  assign lo = SUM_W'(base_i);
  assign hi = SUM_W'(base_i) + SUM_W'(size_i);

  for (genvar g = 0; g < MAP_N; g++) begin : g_map
    if (g < REGIONS) begin : g_live
      assign map[g] = (SUM_W'(g) >= lo) && (SUM_W'(g) < hi);
    end else begin : g_dead
      assign map[g] = 1'b0;
    end
  end

  assign idx = addr_hi_i[REG_IDX_W-1:0];

  if (RA_W > REG_IDX_W) begin : g_upper
    assign in_window = ~|addr_hi_i[RA_W-1:REG_IDX_W];
  end else begin : g_flat
    assign in_window = 1'b1;
  end

  assign hit_o = in_window && map[idx];
endmodule

// File: rtl/acc_downsampler.sv
module acc_downsampler
  import acc_sampler_pkg::*;
#(
  parameter int unsigned DS_LOG2_W = 4,
  parameter int unsigned CNT_W     = 1 << DS_LOG2_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 qual_i,
  input  logic [DS_LOG2_W-1:0] ds_log2_i,
  input  logic                 rand_en_i,
  output logic                 pass_o
);
  logic [CNT_W-1:0]  cnt_q, factor, mask, reload;
  logic [LFSR_W-1:0] lfsr_q, lfsr_nxt;

  assign factor = CNT_W'(1) << ds_log2_i;
  assign mask   = factor - CNT_W'(1);
  assign reload = rand_en_i ? (factor >> 1) + (CNT_W'(lfsr_q) & mask) : mask;
  assign pass_o = qual_i && (cnt_q == '0);

  assign lfsr_nxt = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lfsr_q <= LFSR_SEED;
    end else if (qual_i) begin
      if (cnt_q == '0) begin
        cnt_q  <= reload;
        lfsr_q <= lfsr_nxt;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/acc_sampler.sv
module acc_sampler #(
  parameter int unsigned ADDR_W        = 40,
  parameter int unsigned REGION_LOG2   = 28,
  parameter int unsigned REGIONS       = 16,
  parameter int unsigned MIN_UNIT_LOG2 = 8,
  parameter int unsigned DS_LOG2_W     = 4,
  localparam int unsigned REG_IDX_W    = $clog2(REGIONS),
  localparam int unsigned REG_SIZE_W   = $clog2(REGIONS + 1),
  localparam int unsigned UNIT_W       = ADDR_W - MIN_UNIT_LOG2,
  localparam int unsigned UNIT_LOG2_W  = $clog2(ADDR_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   evt_valid_i,
  input  logic [ADDR_W-1:0]      evt_addr_i,
  input  logic                   evt_write_i,
  input  logic                   evt_trusted_i,
  input  logic [2:0]             cfg_acc_code_i,
  input  logic [REG_IDX_W-1:0]   cfg_region_base_i,
  input  logic [REG_SIZE_W-1:0]  cfg_region_size_i,
  input  logic [UNIT_LOG2_W-1:0] cfg_unit_log2_i,
  input  logic [DS_LOG2_W-1:0]   cfg_ds_log2_i,
  input  logic                   cfg_ds_rand_i,
  output logic                   out_valid_o,
  output logic [UNIT_W-1:0]      out_unit_o
);
  localparam int unsigned RA_W = ADDR_W - REGION_LOG2;

  logic type_ok, region_ok, qual, pass;
  logic [UNIT_LOG2_W-1:0] shift_amt;
  logic [UNIT_W-1:0]      unit_idx;
  logic                   addr_lsb_unused;

  acc_type_filter u_type (
    .code_i    (cfg_acc_code_i),
    .write_i   (evt_write_i),
    .trusted_i (evt_trusted_i),
    .match_o   (type_ok)
  );

  acc_region_map #(
    .RA_W       (RA_W),
    .REGIONS    (REGIONS),
    .REG_IDX_W  (REG_IDX_W),
    .REG_SIZE_W (REG_SIZE_W)
  ) u_region (
    .addr_hi_i (evt_addr_i[ADDR_W-1:REGION_LOG2]),
    .base_i    (cfg_region_base_i),
    .size_i    (cfg_region_size_i),
    .hit_o     (region_ok)
  );

  assign qual = evt_valid_i && type_ok && region_ok;

  acc_downsampler #(
    .DS_LOG2_W (DS_LOG2_W)
  ) u_ds (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .qual_i    (qual),
    .ds_log2_i (cfg_ds_log2_i),
    .rand_en_i (cfg_ds_rand_i),
    .pass_o    (pass)
  );

  // exponents below the floor clamp to the floor
  assign shift_amt = (cfg_unit_log2_i < UNIT_LOG2_W'(MIN_UNIT_LOG2)) ? '0
                   : cfg_unit_log2_i - UNIT_LOG2_W'(MIN_UNIT_LOG2);
  assign unit_idx  = evt_addr_i[ADDR_W-1:MIN_UNIT_LOG2] >> shift_amt;
  assign addr_lsb_unused = ^evt_addr_i[MIN_UNIT_LOG2-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_unit_o  <= '0;
    end else begin
      out_valid_o <= pass;
      if (pass) out_unit_o <= unit_idx;
    end
  end
endmodule

// File: rtl/acc_sampler_chk.sv
module acc_sampler_chk
  import acc_sampler_pkg::*;
#(
  parameter int unsigned ADDR_W        = 40,
  parameter int unsigned REG_IDX_W     = 4,
  parameter int unsigned REG_SIZE_W    = 5,
  parameter int unsigned REGIONS       = 16,
  parameter int unsigned MIN_UNIT_LOG2 = 8,
  parameter int unsigned UNIT_LOG2_W   = 6,
  parameter int unsigned DS_LOG2_W     = 4,
  parameter int unsigned UNIT_W        = 32,
  parameter int unsigned WIN_TOP       = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   evt_valid_i,
  input logic [ADDR_W-1:0]      evt_addr_i,
  input logic                   evt_write_i,
  input logic                   evt_trusted_i,
  input logic [2:0]             cfg_acc_code_i,
  input logic [REG_IDX_W-1:0]   cfg_region_base_i,
  input logic [REG_SIZE_W-1:0]  cfg_region_size_i,
  input logic [UNIT_LOG2_W-1:0] cfg_unit_log2_i,
  input logic [DS_LOG2_W-1:0]   cfg_ds_log2_i,
  input logic                   cfg_ds_rand_i,
  input logic                   out_valid_o,
  input logic [UNIT_W-1:0]      out_unit_o
);
  AST_RESERVED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_acc_code_i == ACC_NONE || cfg_acc_code_i == ACC_RSVD) |=> !out_valid_o); // R4

  AST_OPEN_SKIPS_TRUSTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_trusted_i && cfg_acc_code_i >= ACC_RD_OPEN && cfg_acc_code_i <= ACC_RW_OPEN) |=> !out_valid_o); // R2

  AST_READ_ALL_SKIPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_write_i && cfg_acc_code_i == ACC_RD_ALL) |=> !out_valid_o); // R3

  AST_ABOVE_WINDOW_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_addr_i[ADDR_W-1:WIN_TOP]) |=> !out_valid_o); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> !out_valid_o); // R9

  AST_FULL_RATE_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && cfg_acc_code_i == ACC_RW_ALL && cfg_region_base_i == '0 &&
     cfg_region_size_i == REG_SIZE_W'(REGIONS) && cfg_ds_log2_i == '0 && !cfg_ds_rand_i &&
     cfg_unit_log2_i <= UNIT_LOG2_W'(MIN_UNIT_LOG2) && ~|evt_addr_i[ADDR_W-1:WIN_TOP])
    |=> out_valid_o && out_unit_o == $past(evt_addr_i[ADDR_W-1:MIN_UNIT_LOG2])); // R7
endmodule

bind acc_sampler acc_sampler_chk #(
  .ADDR_W        (ADDR_W),
  .REG_IDX_W     (REG_IDX_W),
  .REG_SIZE_W    (REG_SIZE_W),
  .REGIONS       (REGIONS),
  .MIN_UNIT_LOG2 (MIN_UNIT_LOG2),
  .UNIT_LOG2_W   (UNIT_LOG2_W),
  .DS_LOG2_W     (DS_LOG2_W),
  .UNIT_W        (UNIT_W),
  .WIN_TOP       (REGION_LOG2 + REG_IDX_W)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .evt_valid_i       (evt_valid_i),
  .evt_addr_i        (evt_addr_i),
  .evt_write_i       (evt_write_i),
  .evt_trusted_i     (evt_trusted_i),
  .cfg_acc_code_i    (cfg_acc_code_i),
  .cfg_region_base_i (cfg_region_base_i),
  .cfg_region_size_i (cfg_region_size_i),
  .cfg_unit_log2_i   (cfg_unit_log2_i),
  .cfg_ds_log2_i     (cfg_ds_log2_i),
  .cfg_ds_rand_i     (cfg_ds_rand_i),
  .out_valid_o       (out_valid_o),
  .out_unit_o        (out_unit_o)
);

// File: tb/acc_sampler_bench.sv
`timescale 1ns/1ps
module acc_sampler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [39:0] evt_addr = '0;
  logic        evt_write = 1'b0;
  logic        evt_trusted = 1'b0;
  logic [2:0]  cfg_code = 3'd6;
  logic [3:0]  cfg_base = 4'd0;
  logic [4:0]  cfg_size = 5'd16;
  logic [5:0]  cfg_unit = 6'd8;
  logic [3:0]  cfg_ds = 4'd0;
  logic        cfg_rand = 1'b0;
  logic        out_valid;
  logic [31:0] out_unit;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] exp_unit[$];
  int          exp_due[$];
  string       exp_tag[$];

  // reference state
  int unsigned m_cnt = 0;
  logic [15:0] m_lfsr = 16'hACE1;

  always #4 clk = ~clk;

  acc_sampler u_acc_sampler (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .evt_valid_i       (evt_valid),
    .evt_addr_i        (evt_addr),
    .evt_write_i       (evt_write),
    .evt_trusted_i     (evt_trusted),
    .cfg_acc_code_i    (cfg_code),
    .cfg_region_base_i (cfg_base),
    .cfg_region_size_i (cfg_size),
    .cfg_unit_log2_i   (cfg_unit),
    .cfg_ds_log2_i     (cfg_ds),
    .cfg_ds_rand_i     (cfg_rand),
    .out_valid_o       (out_valid),
    .out_unit_o        (out_unit)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit type_ok(logic [2:0] c, logic w, logic t);
    case (c)
      3'd1: return !w && !t;
      3'd2: return w && !t;
      3'd3: return !t;
      3'd4: return !w;
      3'd5: return w;
      3'd6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit region_ok(logic [39:0] a);
    int i;
    if (a[39:32] != 0) return 1'b0;
    i = int'(a[31:28]);
    return (i >= int'(cfg_base)) && (i < int'(cfg_base) + int'(cfg_size));
  endfunction

  function automatic logic [31:0] unit_of(logic [39:0] a);
    int e;
    logic [39:0] s;
    e = (cfg_unit < 6'd8) ? 8 : int'(cfg_unit);
    s = a >> e;
    return s[31:0];
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [39:0] a, logic w, logic t, string tag);
    int unsigned f;
    @(negedge clk);
    evt_valid = 1'b1; evt_addr = a; evt_write = w; evt_trusted = t;
    if (type_ok(cfg_code, w, t) && region_ok(a)) begin
      if (m_cnt == 0) begin
        exp_unit.push_back(unit_of(a));
        exp_due.push_back(cyc + 1);
        exp_tag.push_back(tag);
        f = 32'd1 << cfg_ds;
        m_cnt = cfg_rand ? (f >> 1) + (int'(m_lfsr) & (f - 1)) : f - 1;
        m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 16'hB400) : (m_lfsr >> 1);
      end else begin
        m_cnt--;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_valid = 1'b0;
    end
  endtask

  task automatic drain(string tag);
    idle(3);
    check(exp_unit.size() == 0, tag, "missing outputs", exp_unit.size(), 0);
    exp_unit.delete(); exp_due.delete(); exp_tag.delete();
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_unit.size() > 0 && exp_due[0] < cyc) begin
        check(1'b0, exp_tag[0], "no pulse at due cycle", cyc, exp_due[0]);
        void'(exp_unit.pop_front()); void'(exp_due.pop_front()); void'(exp_tag.pop_front());
      end
      if (out_valid) begin
        if (exp_unit.size() == 0) begin
          check(1'b0, "R9", "unexpected pulse", out_unit, 0);
        end else begin
          check(exp_due[0] == cyc, "R9", "pulse cycle", cyc, exp_due[0]);
          check(out_unit == exp_unit[0], exp_tag[0], "unit index", out_unit, exp_unit[0]);
          void'(exp_unit.pop_front()); void'(exp_due.pop_front()); void'(exp_tag.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);

    // R1: first event after reset passes; R6 unit index with several exponents
    send(40'h00_1234_5678, 1'b0, 1'b0, "R1");
    idle(1);
    cfg_unit = 6'd12; send(40'h00_9ABC_DEF0, 1'b1, 1'b1, "R6");
    idle(1);
    cfg_unit = 6'd20; send(40'h00_FFFF_FFFF, 1'b0, 1'b1, "R6");
    idle(1);
    cfg_unit = 6'd3;  send(40'h00_0000_0A55, 1'b0, 1'b0, "R6");
    idle(1);
    cfg_unit = 6'd39; send(40'h00_F000_0000, 1'b1, 1'b0, "R6");
    idle(1);
    cfg_unit = 6'd8;
    drain("R6");

    // R2 R3 R4: every code against every flag pair, back to back
    for (int c = 0; c < 8; c++) begin
      idle(1);
      cfg_code = 3'(c);
      for (int p = 0; p < 4; p++)
        send(40'h00_2345_6700 + 40'(p << 8), p[0], p[1],
             (c == 0 || c == 7) ? "R4" : (c < 4 ? "R2" : "R3"));
    end
    drain("R4");

    // R5: region window and clipping
    idle(1);
    cfg_code = 3'd6; cfg_base = 4'd3; cfg_size = 5'd4;
    send(40'h00_2000_0000, 1'b0, 1'b0, "R5");
    send(40'h00_3000_0100, 1'b0, 1'b0, "R5");
    send(40'h00_6FFF_FFFF, 1'b0, 1'b0, "R5");
    send(40'h00_7000_0000, 1'b0, 1'b0, "R5");
    send(40'h01_3000_0000, 1'b0, 1'b0, "R5");
    idle(1);
    cfg_base = 4'd14; cfg_size = 5'd5;
    send(40'h00_D000_0000, 1'b1, 1'b0, "R5");
    send(40'h00_E123_4500, 1'b1, 1'b0, "R5");
    send(40'h00_F000_0300, 1'b1, 1'b0, "R5");
    send(40'h00_0000_0400, 1'b1, 1'b0, "R5");
    send(40'h80_F000_0000, 1'b1, 1'b0, "R5");
    idle(1);
    cfg_base = 4'd0; cfg_size = 5'd0;
    send(40'h00_0000_0500, 1'b0, 1'b0, "R5");
    drain("R5");

    // R7: fixed factor 4, dropped events interleaved must not advance
    idle(1);
    cfg_size = 5'd16; cfg_code = 3'd1; cfg_ds = 4'd2;
    for (int i = 0; i < 24; i++) begin
      send(40'h00_0100_0000 + 40'(i << 12), 1'b0, 1'b0, "R7");
      if (i % 3 == 0) send(40'h00_0200_0000, 1'b1, 1'b0, "R7");
      if (i % 5 == 0) idle(2);
    end
    drain("R7");

    // R8: randomized intervals
    idle(1);
    cfg_code = 3'd6; cfg_ds = 4'd3; cfg_rand = 1'b1;
    for (int i = 0; i < 300; i++)
      send(40'h00_4000_0000 + 40'(i << 9), i[0], i[1], "R8");
    idle(1);
    cfg_ds = 4'd0;
    for (int i = 0; i < 6; i++) send(40'h00_5000_0000 + 40'(i << 8), 1'b0, 1'b0, "R8");
    drain("R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule